// File: doc/BRIEF.md
# Multi-Tap Peripheral Clock Prescaler

This block derives slower clock enables for several peripherals from one source. A register bit picks the source: either the high-speed or the low-speed clock, each presented as a one-cycle enable pulse in the system clock domain. A free-running binary counter advances on each tick of the chosen source. Three taps watch that counter, one each for timer channel 2, timer channel 3 and the converter channel. Each tap gives a one-cycle pulse at its own divided rate. A global run input stops the counter and clears it to zero. While it is low, no channel emits a pulse.

Software sets each channel's enable and its 3-bit ratio code through a small byte-wide register port. Timer channel 2 has an extended table: its two highest codes reach much lower rates than the other channels can. Every output is a registered clock-enable, meant to qualify logic in the same clock domain.

Top module: `periph_prescaler`

## Requirements
- R1: Address 0 holds the timer byte. Bit 7 enables channel 3, bits 6:4 are the channel 3 code, bit 3 enables channel 2 and bits 2:0 are the channel 2 code. It resets to 0x00 and reads back exactly as written.
- R2: Address 1 holds the converter byte: bit 3 is its enable and bits 2:0 are its code. Bits 7:4 are not stored and always read as 0. It resets to 0x00.
- R3: Address 2 bit 0 selects the source, where 1 means the low-speed tick and 0 means the high-speed tick. It resets to 0, its other bits read as 0, and ticks of the unselected source have no effect. Address 3 reads as 0x00.
- R4: On channel 3 and on the converter channel, code c divides the selected source by 2^(c+1), so codes 0 to 7 give /2 up to /256.
- R5: On channel 2, codes 0 to 5 divide by 2 to 64 as in R4, code 6 divides by 2048 and code 7 divides by 4096.
- R6: A channel whose enable bit is 0 produces no pulses.
- R7: While the run input is 0, the counter is held at zero and no output pulses. After the run input returns to 1, a /N channel pulses on the N-th source tick.
- R8: A channel pulses when a source tick arrives while the counter bits below its tap are all ones. The pulse is one cycle wide and appears on the output one clock after that tick.
- R9: rdata is registered. It shows the register selected by addr one clock later, as the register stood before any write made on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_tick | input | 1 | High-speed source enable pulse |
| ls_tick | input | 1 | Low-speed source enable pulse |
| presc_on | input | 1 | Global run; 0 stops and clears the divider |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tick_t2 | output | 1 | Timer channel 2 clock enable |
| tick_t3 | output | 1 | Timer channel 3 clock enable |
| tick_adc | output | 1 | Converter clock enable |

## Verification
The source tick that meets a tap's all-ones condition is sampled on clock edge N, and the matching output pulse can be observed in the half cycle after that edge. Read data for an address presented before edge N is likewise due right after edge N. The bench drives inputs on the falling edge. Before each rising edge it computes the expected outputs from the register and counter state it keeps itself, then compares them on the next falling edge, so every check lands exactly one register stage after its stimulus. For the long ratios, the bench also counts pulses over a fixed number of ticks.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;
  localparam int CNT_W   = 12;
  localparam int RATIO_W = 3;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int N_CH    = 3;
  localparam int TAP_W   = $clog2(CNT_W + 1);

  // channel indices
  localparam int CH_T2  = 0;
  localparam int CH_T3  = 1;
  localparam int CH_ADC = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_TMR = 2'd0,
    REG_ADC = 2'd1,
    REG_SRC = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  // counter width below the tap, i.e. log2 of the division ratio
  function automatic logic [TAP_W-1:0] tap_of(input logic [RATIO_W-1:0] code,
                                              input logic ext);
    logic [TAP_W-1:0] t;
    if (ext && code >= RATIO_W'(6)) t = TAP_W'(code) + TAP_W'(5);
    else                            t = TAP_W'(code) + TAP_W'(1);
    return t;
  endfunction
endpackage

// File: rtl/prescaler_regs.sv
module prescaler_regs
  import prescaler_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [N_CH-1:0]               ch_en,
  output logic [N_CH-1:0][RATIO_W-1:0]  ch_code,
  output logic                          src_low
);
  logic [DATA_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_en   <= '0;
      ch_code <= '0;
      src_low <= 1'b0;
    end else if (wr_en) begin
      case (reg_addr_e'(addr))
        REG_TMR: begin
          ch_en[CH_T3]   <= wdata[7];
          ch_code[CH_T3] <= wdata[6:4];
          ch_en[CH_T2]   <= wdata[3];
          ch_code[CH_T2] <= wdata[2:0];
        end
        REG_ADC: begin
          ch_en[CH_ADC]   <= wdata[3];
          ch_code[CH_ADC] <= wdata[2:0];
        end
        REG_SRC: src_low <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (reg_addr_e'(addr))
      REG_TMR: rd_next = {ch_en[CH_T3], ch_code[CH_T3], ch_en[CH_T2], ch_code[CH_T2]};
      REG_ADC: rd_next = {4'b0000, ch_en[CH_ADC], ch_code[CH_ADC]};
      REG_SRC: rd_next = {{(DATA_W-1){1'b0}}, src_low};
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/prescaler_divider.sv
module prescaler_divider #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         adv,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (adv)    cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/prescaler_tap.sv
module prescaler_tap
  import prescaler_pkg::*;
#(
  parameter bit EXT = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic               en,
  input  logic [RATIO_W-1:0] code,
  input  logic [CNT_W-1:0]   cnt,
  output logic               tick
);
  logic [TAP_W-1:0] tap;
  logic [CNT_W-1:0] mask;
  logic             hit;

  always_comb begin
    tap  = tap_of(code, EXT);
    mask = (CNT_W'(1) << tap) - CNT_W'(1);
    hit  = ((cnt & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= fire && en && hit;
  end
endmodule

// File: rtl/periph_prescaler.sv
module periph_prescaler
  import prescaler_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_tick,
  input  logic              ls_tick,
  input  logic              presc_on,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tick_t2,
  output logic              tick_t3,
  output logic              tick_adc
);
  localparam logic [N_CH-1:0] EXT_MASK = N_CH'(1) << CH_T2;

  logic [N_CH-1:0]              ch_en;
  logic [N_CH-1:0][RATIO_W-1:0] ch_code;
  logic                         src_low;
  logic                         src_tick;
  logic [CNT_W-1:0]             div_cnt;
  logic [N_CH-1:0]              ch_tick;

  prescaler_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ch_en(ch_en), .ch_code(ch_code), .src_low(src_low)
  );

  assign src_tick = src_low ? ls_tick : hs_tick;

  prescaler_divider #(.W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .run(presc_on), .adv(src_tick), .cnt(div_cnt)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    prescaler_tap #(.EXT(EXT_MASK[i])) u_tap (
      .clk(clk), .rst(rst), .fire(presc_on && src_tick),
      .en(ch_en[i]), .code(ch_code[i]), .cnt(div_cnt), .tick(ch_tick[i])
    );
  end

  assign tick_t2  = ch_tick[CH_T2];
  assign tick_t3  = ch_tick[CH_T3];
  assign tick_adc = ch_tick[CH_ADC];
endmodule

// File: rtl/prescaler_checker.sv
module prescaler_checker
  import prescaler_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              presc_on,
  input logic              src_tick,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [N_CH-1:0]   ch_en,
  input logic [N_CH-1:0]   ch_tick,
  input logic [CNT_W-1:0]  div_cnt
);
  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !presc_on |=> (ch_tick == '0 && div_cnt == '0));

  assert_dis_t2_R6: assert property (@(posedge clk) disable iff (rst)
    !ch_en[CH_T2] |=> !ch_tick[CH_T2]);
  assert_dis_t3_R6: assert property (@(posedge clk) disable iff (rst)
    !ch_en[CH_T3] |=> !ch_tick[CH_T3]);
  assert_dis_adc_R6: assert property (@(posedge clk) disable iff (rst)
    !ch_en[CH_ADC] |=> !ch_tick[CH_ADC]);

  assert_needs_src_R8: assert property (@(posedge clk) disable iff (rst)
    !src_tick |=> (ch_tick == '0));

  assert_single_R8: assert property (@(posedge clk) disable iff (rst)
    (ch_tick != '0) |=> ((ch_tick & $past(ch_tick)) == '0));

  assert_reserved_R2: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(1)) |=> (rdata[7:4] == 4'b0000));
endmodule

bind periph_prescaler prescaler_checker u_chk (
  .clk(clk), .rst(rst), .presc_on(presc_on), .src_tick(src_tick),
  .addr(addr), .rdata(rdata), .ch_en(ch_en), .ch_tick(ch_tick),
  .div_cnt(div_cnt)
);

// File: tb/periph_prescaler_tb.sv
module periph_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hs_tick = 1'b0, ls_tick = 1'b0, presc_on = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       tick_t2, tick_t3, tick_adc;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  periph_prescaler u_dut (
    .clk(clk), .rst(rst), .hs_tick(hs_tick), .ls_tick(ls_tick),
    .presc_on(presc_on), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick_t2(tick_t2), .tick_t3(tick_t3), .tick_adc(tick_adc)
  );

  // bench model of the registers and counter
  logic [11:0] m_cnt = '0;
  logic [2:0]  m_en  = '0;          // 0=t2 1=t3 2=adc
  logic [2:0]  m_code [3] = '{3'd0, 3'd0, 3'd0};
  logic        m_src = 1'b0;
  int          pulses_t2 = 0;

  function automatic int ratio_log(input int ch, input logic [2:0] c);
    if (ch == 0 && c == 3'd6) return 11;   // R5: /2048
    if (ch == 0 && c == 3'd7) return 12;   // R5: /4096
    return int'(c) + 1;                     // R4
  endfunction

  function automatic logic [7:0] rd_model(input logic [1:0] a);
    case (a)
      2'd0: return {m_en[1], m_code[1], m_en[0], m_code[0]};
      2'd1: return {4'b0, m_en[2], m_code[2]};
      2'd2: return {7'b0, m_src};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, predict, step, compare at next negedge
  task automatic cyc(input logic hs, input logic ls, input logic on,
                     input logic we, input logic [1:0] a, input logic [7:0] d,
                     input string req);
    logic       tk;
    logic [2:0] exp_t;
    logic [7:0] exp_rd;
    hs_tick = hs; ls_tick = ls; presc_on = on;
    wr_en = we; addr = a; wdata = d;
    tk = m_src ? ls : hs;
    for (int ch = 0; ch < 3; ch++) begin
      logic [11:0] mk;
      mk = 12'((13'd1 << ratio_log(ch, m_code[ch])) - 13'd1);
      exp_t[ch] = on && tk && m_en[ch] && ((m_cnt & mk) == mk);
    end
    exp_rd = rd_model(a);
    if (!on) m_cnt = '0;
    else if (tk) m_cnt = m_cnt + 12'd1;
    if (we) begin
      case (a)
        2'd0: begin m_en[1] = d[7]; m_code[1] = d[6:4]; m_en[0] = d[3]; m_code[0] = d[2:0]; end
        2'd1: begin m_en[2] = d[3]; m_code[2] = d[2:0]; end
        2'd2: m_src = d[0];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    if (tick_t2) pulses_t2++;
    check({req, " tick_t2"},  int'(tick_t2),  int'(exp_t[0]));
    check({req, " tick_t3"},  int'(tick_t3),  int'(exp_t[1]));
    check({req, " tick_adc"}, int'(tick_adc), int'(exp_t[2]));
    check("R9 rdata", int'(rdata), int'(exp_rd));
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1/R2/R3 reset state read through the port
    cyc(0, 0, 1, 0, 2'd0, 8'h00, "R1 reset");
    check("R1 reset timer byte", int'(rdata), 0);
    cyc(0, 0, 1, 0, 2'd1, 8'h00, "R2 reset");
    check("R2 reset conv byte", int'(rdata), 0);
    cyc(0, 0, 1, 0, 2'd2, 8'h00, "R3 reset");
    check("R3 reset source", int'(rdata), 0);

    // R1 layout: ch3 en, code 2; ch2 en, code 1
    cyc(0, 0, 1, 1, 2'd0, 8'hA9, "R1 write");
    cyc(0, 0, 1, 0, 2'd0, 8'h00, "R1 read");
    check("R1 readback", int'(rdata), 8'hA9);
    // R2 reserved bits
    cyc(0, 0, 1, 1, 2'd1, 8'hFC, "R2 write");
    cyc(0, 0, 1, 0, 2'd1, 8'h00, "R2 read");
    check("R2 reserved read zero", int'(rdata), 8'h0C);
    cyc(0, 0, 1, 0, 2'd3, 8'h00, "R3 addr3");
    check("R3 unused address", int'(rdata), 0);

    // R7: clear counter, then R4/R8 with ticks every cycle
    cyc(0, 0, 0, 0, 2'd0, 8'h00, "R7 off");
    for (int i = 0; i < 64; i++) cyc(1, 0, 1, 0, 2'd0, 8'h00, "R4 hs run");
    // R7: off while ticking gives nothing
    for (int i = 0; i < 16; i++) cyc(1, 1, 0, 0, 2'd0, 8'h00, "R7 off ticking");

    // R3: low-speed source, hs ticks ignored
    cyc(0, 0, 1, 1, 2'd2, 8'hFF, "R3 sel");
    cyc(0, 0, 1, 0, 2'd2, 8'h00, "R3 read");
    check("R3 source readback", int'(rdata), 1);
    for (int i = 0; i < 40; i++) cyc(1, i[1], 1, 0, 2'd0, 8'h00, "R3 ls only");
    cyc(0, 0, 1, 1, 2'd2, 8'h00, "R3 sel hs");

    // R6: all disabled, hs every cycle
    cyc(0, 0, 1, 1, 2'd0, 8'h00, "R6 dis");
    cyc(0, 0, 1, 1, 2'd1, 8'h00, "R6 dis");
    for (int i = 0; i < 64; i++) cyc(1, 1, 1, 0, 2'd0, 8'h00, "R6 disabled");

    // R5: channel 2 code 7 and code 6 long runs
    cyc(0, 0, 0, 1, 2'd0, 8'h0F, "R5 set");
    pulses_t2 = 0;
    for (int i = 0; i < 8192; i++) cyc(1, 0, 1, 0, 2'd0, 8'h00, "R5 div4096");
    check("R5 /4096 pulse count", pulses_t2, 2);
    cyc(0, 0, 0, 1, 2'd0, 8'h0E, "R5 set");
    pulses_t2 = 0;
    for (int i = 0; i < 4096; i++) cyc(1, 0, 1, 0, 2'd0, 8'h00, "R5 div2048");
    check("R5 /2048 pulse count", pulses_t2, 2);

    // R7: after restart a /4 channel pulses on the 4th tick
    cyc(0, 0, 1, 1, 2'd1, 8'h09, "R7 set");
    cyc(0, 0, 0, 0, 2'd0, 8'h00, "R7 off");
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 2'd0, 8'h00, "R7 restart");
    check("R7 no pulse before 4th tick", int'(tick_adc), 0);
    cyc(1, 0, 1, 0, 2'd0, 8'h00, "R7 restart");
    check("R7 pulse on 4th tick", int'(tick_adc), 1);

    // random mix over all requirements
    for (int i = 0; i < 6000; i++) begin
      logic we;
      we = ($urandom_range(0, 19) == 0);
      cyc(($urandom_range(0, 1) == 1), ($urandom_range(0, 3) == 0),
          ($urandom_range(0, 49) != 0), we, 2'($urandom_range(0, 3)),
          8'($urandom_range(0, 255)), "R4 R5 R6 R7 R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule